// File: doc/BRIEF.md
# BT Host Register Interface

This block is the host-side register window of a block-transfer message interface. Three byte-wide registers sit in the window: a handshake/control register, a data port and an interrupt mask. A host loads a request byte by byte through the data port and then raises an attention flag. It collects the response through the same data port. The block keeps both message buffers, every handshake flag and the one level-sensitive interrupt line to the host.

The far side (the management controller) reaches the block through strobes. A one-cycle `req_ready` pulse tells it that a request is complete. It then reads the request bytes through an indexed read port, fills the response buffer through an indexed write port, and posts the response with its length. It can also raise or drop a separate message-attention flag. The block does not parse messages.

Top module: `bt_host_regs`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00, the mask register reads 0x00, `irq` is 0 and the request count is 0.
- R2: `host_addr` selects the register: 0 is control, 1 is data, 2 is mask. A read of address 3 returns 0xFF. Control read layout: bit7 is controller busy, bit6 is host busy, bit4 is message attention, bit3 is response attention. Bits 5, 2, 1 and 0 read 0. Mask read layout: bit0 is enable, bit1 is pending, and the other bits read 0.
- R3: A data write stores the byte at the current request count only while the count is below `REQ_DEPTH`. The count increments on every data write and saturates at its all-ones value. Bytes that are already stored are never overwritten by overrun writes.
- R4: A control write with bit0 set zeroes the request count. A control write with bit2 set sets controller busy, and `req_ready` is high for exactly the one cycle after that write.
- R5: A data read returns the response byte at the read position and advances the position. The read that returns the last byte zeroes both the position and the response length. A data read with no bytes left returns 0xFF.
- R6: A control write with bit1 set returns the response read position to 0, so the response is read again from its first byte.
- R7: A control write with bit6 set toggles host busy.
- R8: A control write with bit3 set clears response attention. A control write with bit4 set clears message attention. A 0 in either bit leaves that flag unchanged.
- R9: A mask write that changes enable from 0 to 1 sets pending when response or message attention is set. `irq` always equals pending.
- R10: A mask write that changes enable from 1 to 0 clears pending. A mask write with bit1 set also clears pending.
- R11: `rsp_post` loads the response length (clamped to `RSP_DEPTH`), clears controller busy and sets response attention. It sets pending when enable is 1.
- R12: `sms_set` sets message attention and, when it was clear, sets pending if enable is 1 and response attention is 0. `sms_clr` clears message attention and, when response attention is 0, clears pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select within the window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (data reads advance the position) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Level interrupt to the host |
| req_ready | output | 1 | One-cycle pulse: request complete |
| req_len | output | CNT_W | Request byte count (may exceed REQ_DEPTH on overrun) |
| req_ridx | input | $clog2(REQ_DEPTH) | Request buffer read index |
| req_rbyte | output | 8 | Request byte at req_ridx |
| rsp_we | input | 1 | Response buffer write strobe |
| rsp_widx | input | $clog2(RSP_DEPTH) | Response buffer write index |
| rsp_wbyte | input | 8 | Response byte to store |
| rsp_post | input | 1 | Post the response |
| rsp_plen | input | $clog2(RSP_DEPTH+1) | Length of the posted response |
| sms_set | input | 1 | Raise message attention |
| sms_clr | input | 1 | Drop message attention |

## Verification
A wrong flag shows on the control or mask byte at the next register read. A wrong pending bit also shows on `irq` one cycle after the event that set or cleared it. A corrupted read position or response length shows as a wrong byte, or as 0xFF too early or too late, on the data port within one read. A wrong request count shows on `req_len` in the cycle after the write. Overrun writes that land in the buffer show on the indexed request read.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_DATA = 2'd1;
    localparam logic [1:0] OFF_MASK = 2'd2;

    localparam int CB_CLR_REQ  = 0;
    localparam int CB_CLR_RSP  = 1;
    localparam int CB_HOST_ATN = 2;
    localparam int CB_RSP_ATN  = 3;
    localparam int CB_MSG_ATN  = 4;
    localparam int CB_HBUSY    = 6;
    localparam int CB_CBUSY    = 7;

    localparam int MB_EN   = 0;
    localparam int MB_PEND = 1;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    typedef struct packed {
        logic cbusy;
        logic hbusy;
        logic msg_atn;
        logic rsp_atn;
    } hs_flags_t;

    function automatic logic [7:0] ctrl_view(hs_flags_t f);
        logic [7:0] b;
        b = '0;
        b[CB_CBUSY]   = f.cbusy;
        b[CB_HBUSY]   = f.hbusy;
        b[CB_MSG_ATN] = f.msg_atn;
        b[CB_RSP_ATN] = f.rsp_atn;
        return b;
    endfunction

    function automatic logic [7:0] mask_view(logic en, logic pend);
        logic [7:0] b;
        b = '0;
        b[MB_EN]   = en;
        b[MB_PEND] = pend;
        return b;
    endfunction

endpackage

// File: rtl/bt_req_buf.sv
module bt_req_buf #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [7:0]       wbyte,
    input  logic             clr,
    input  logic [AW-1:0]    ridx,
    output logic [7:0]       rbyte,
    output logic [CNT_W-1:0] cnt
);
    logic [7:0] mem [DEPTH];
    logic       in_range;

    assign in_range = (cnt < CNT_W'(DEPTH));
    assign rbyte    = mem[ridx];

    always_ff @(posedge clk) begin
        if (wr && in_range) begin
            mem[cnt[AW-1:0]] <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (wr && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr && cnt != '1) |=> (cnt == $past(cnt) + 1'b1)); // R3

endmodule

// File: rtl/bt_rsp_buf.sv
module bt_rsp_buf #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [7:0]    wbyte,
    input  logic          post,
    input  logic [LW-1:0] plen,
    input  logic          rd,
    input  logic          rewind,
    output logic [7:0]    rbyte
);
    import bt_pkg::*;

    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] len;
    logic [LW-1:0] pos;
    logic          avail;
    logic          last;

    assign avail = (pos < len);
    assign last  = avail && (pos + 1'b1 == len);
    assign rbyte = avail ? mem[pos[AW-1:0]] : IDLE_BYTE;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len <= '0;
            pos <= '0;
        end else begin
            if (rewind) begin
                pos <= '0;
            end else if (rd && avail) begin
                pos <= last ? '0 : pos + 1'b1;
            end
            if (post) begin
                len <= (plen > LW'(DEPTH)) ? LW'(DEPTH) : plen;
            end else if (rd && last) begin
                len <= '0;
            end
        end
    end

    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (rd && last && !post) |=> (len == '0 && pos == '0)); // R5
    AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd && avail && !last && !rewind) |=> (pos == $past(pos) + 1'b1)); // R5

endmodule

// File: rtl/bt_flags.sv
module bt_flags (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_we,
    input  logic                 mask_we,
    input  logic [7:0]           wdata,
    input  logic                 rsp_post,
    input  logic                 sms_set,
    input  logic                 sms_clr,
    output bt_pkg::hs_flags_t    fl,
    output logic                 en,
    output logic                 pend,
    output logic                 req_ready
);
    import bt_pkg::*;

    hs_flags_t fl_n;
    logic      en_n;
    logic      pend_n;
    logic      req_n;

    always_comb begin
        fl_n   = fl;
        en_n   = en;
        pend_n = pend;
        req_n  = 1'b0;
        if (ctrl_we) begin
            if (wdata[CB_RSP_ATN]) fl_n.rsp_atn = 1'b0;
            if (wdata[CB_MSG_ATN]) fl_n.msg_atn = 1'b0;
            if (wdata[CB_HBUSY])   fl_n.hbusy   = ~fl_n.hbusy;
            if (wdata[CB_HOST_ATN]) begin
                fl_n.cbusy = 1'b1;
                req_n      = 1'b1;
            end
        end
        if (mask_we) begin
            if (wdata[MB_EN] != en_n) begin
                if (wdata[MB_EN]) begin
                    if (fl_n.rsp_atn || fl_n.msg_atn) pend_n = 1'b1;
                    en_n = 1'b1;
                end else begin
                    pend_n = 1'b0;
                    en_n   = 1'b0;
                end
            end
            if (wdata[MB_PEND] && pend_n) pend_n = 1'b0;
        end
        if (rsp_post) begin
            fl_n.cbusy   = 1'b0;
            fl_n.rsp_atn = 1'b1;
            if (en_n && !pend_n) pend_n = 1'b1;
        end
        if (sms_set && !fl_n.msg_atn) begin
            fl_n.msg_atn = 1'b1;
            if (en_n && !fl_n.rsp_atn) pend_n = 1'b1;
        end else if (sms_clr && fl_n.msg_atn) begin
            fl_n.msg_atn = 1'b0;
            if (!fl_n.rsp_atn && pend_n) pend_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl        <= '0;
            en        <= 1'b0;
            pend      <= 1'b0;
            req_ready <= 1'b0;
        end else begin
            fl        <= fl_n;
            en        <= en_n;
            pend      <= pend_n;
            req_ready <= req_n;
        end
    end

    AST_HBUSY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && wdata[CB_HBUSY]) |=> (fl.hbusy != $past(fl.hbusy))); // R7
    AST_HOST_ATN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && wdata[CB_HOST_ATN] && !rsp_post) |=> (fl.cbusy && req_ready)); // R4
    AST_POST_ATTN: assert property (@(posedge clk) disable iff (rst)
        rsp_post |=> (fl.rsp_atn && !fl.cbusy)); // R11
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mask_we && !wdata[MB_EN] && !rsp_post && !sms_set) |=> !pend); // R10
    AST_SMS_DROP: assert property (@(posedge clk) disable iff (rst)
        (sms_clr && !sms_set) |=> !fl.msg_atn); // R12

endmodule

// File: rtl/bt_host_regs.sv
module bt_host_regs #(
    parameter int REQ_DEPTH = 32,
    parameter int RSP_DEPTH = 32,
    parameter int CNT_W     = 8,
    localparam int REQ_AW = $clog2(REQ_DEPTH),
    localparam int RSP_AW = $clog2(RSP_DEPTH),
    localparam int RSP_LW = $clog2(RSP_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq,
    output logic              req_ready,
    output logic [CNT_W-1:0]  req_len,
    input  logic [REQ_AW-1:0] req_ridx,
    output logic [7:0]        req_rbyte,
    input  logic              rsp_we,
    input  logic [RSP_AW-1:0] rsp_widx,
    input  logic [7:0]        rsp_wbyte,
    input  logic              rsp_post,
    input  logic [RSP_LW-1:0] rsp_plen,
    input  logic              sms_set,
    input  logic              sms_clr
);
    import bt_pkg::*;

    logic      ctrl_we, mask_we, data_we, data_rd;
    hs_flags_t fl;
    logic      en, pend;
    logic [7:0] rsp_byte;

    assign ctrl_we = host_wr && (host_addr == OFF_CTRL);
    assign mask_we = host_wr && (host_addr == OFF_MASK);
    assign data_we = host_wr && (host_addr == OFF_DATA);
    assign data_rd = host_rd && (host_addr == OFF_DATA);

    bt_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .mask_we   (mask_we),
        .wdata     (host_wdata),
        .rsp_post  (rsp_post),
        .sms_set   (sms_set),
        .sms_clr   (sms_clr),
        .fl        (fl),
        .en        (en),
        .pend      (pend),
        .req_ready (req_ready)
    );

    bt_req_buf #(.DEPTH(REQ_DEPTH), .CNT_W(CNT_W)) u_req (
        .clk   (clk),
        .rst   (rst),
        .wr    (data_we),
        .wbyte (host_wdata),
        .clr   (ctrl_we && host_wdata[CB_CLR_REQ]),
        .ridx  (req_ridx),
        .rbyte (req_rbyte),
        .cnt   (req_len)
    );

    bt_rsp_buf #(.DEPTH(RSP_DEPTH)) u_rsp (
        .clk    (clk),
        .rst    (rst),
        .we     (rsp_we),
        .widx   (rsp_widx),
        .wbyte  (rsp_wbyte),
        .post   (rsp_post),
        .plen   (rsp_plen),
        .rd     (data_rd),
        .rewind (ctrl_we && host_wdata[CB_CLR_RSP]),
        .rbyte  (rsp_byte)
    );

    always_comb begin
        case (host_addr)
            OFF_CTRL: host_rdata = ctrl_view(fl);
            OFF_DATA: host_rdata = rsp_byte;
            OFF_MASK: host_rdata = mask_view(en, pend);
            default:  host_rdata = IDLE_BYTE;
        endcase
    end

    assign irq = pend;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> en); // R9
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (irq && !host_wr && !sms_clr) |=> irq); // R9

endmodule

// File: tb/bt_host_regs_tb_top.sv
`timescale 1ns/1ps
module bt_host_regs_tb_top;
    localparam int REQ_DEPTH = 8;
    localparam int RSP_DEPTH = 8;
    localparam int CNT_W     = 8;
    localparam int REQ_AW = $clog2(REQ_DEPTH);
    localparam int RSP_AW = $clog2(RSP_DEPTH);
    localparam int RSP_LW = $clog2(RSP_DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] host_addr = '0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic irq, req_ready;
    logic [CNT_W-1:0] req_len;
    logic [REQ_AW-1:0] req_ridx = '0;
    logic [7:0] req_rbyte;
    logic rsp_we = 1'b0;
    logic [RSP_AW-1:0] rsp_widx = '0;
    logic [7:0] rsp_wbyte = '0;
    logic rsp_post = 1'b0;
    logic [RSP_LW-1:0] rsp_plen = '0;
    logic sms_set = 1'b0, sms_clr = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    bt_host_regs #(.REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .req_ready(req_ready),
        .req_len(req_len), .req_ridx(req_ridx), .req_rbyte(req_rbyte), .rsp_we(rsp_we),
        .rsp_widx(rsp_widx), .rsp_wbyte(rsp_wbyte), .rsp_post(rsp_post), .rsp_plen(rsp_plen),
        .sms_set(sms_set), .sms_clr(sms_clr)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every host read, away from the edge
    always @(negedge clk) begin
        if (host_rd) begin
            if (exp_q.size() == 0) begin
                check(32'hDEAD, 32'h0, "scoreboard underflow");
            end else begin
                check(32'(host_rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
            end
        end
    end

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic bmc_byte(input int idx, input logic [7:0] b);
        @(posedge clk); #1;
        rsp_widx = RSP_AW'(idx); rsp_wbyte = b; rsp_we = 1'b1;
        @(posedge clk); #1;
        rsp_we = 1'b0;
    endtask

    task automatic bmc_post(input int n);
        @(posedge clk); #1;
        rsp_plen = RSP_LW'(n); rsp_post = 1'b1;
        @(posedge clk); #1;
        rsp_post = 1'b0;
    endtask

    task automatic bmc_sms(input logic up);
        @(posedge clk); #1;
        sms_set = up; sms_clr = !up;
        @(posedge clk); #1;
        sms_set = 1'b0; sms_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R2 reset values and window decode
        check(32'(irq), 0, "R1 irq after reset");
        check(32'(req_len), 0, "R1 request count after reset");
        hread(2'd0, 8'h00, "R1 control after reset");
        hread(2'd2, 8'h00, "R1 mask after reset");
        hread(2'd1, 8'hFF, "R5 empty data read");
        hread(2'd3, 8'hFF, "R2 unused offset");

        // R3 request loading
        hwrite(2'd1, 8'hAA); hwrite(2'd1, 8'hBB); hwrite(2'd1, 8'hCC);
        check(32'(req_len), 3, "R3 count after three writes");
        #1 req_ridx = 1;
        #1 check(32'(req_rbyte), 32'hBB, "R3 stored byte 1");

        // R4 host attention
        hwrite(2'd0, 8'h04);
        check(32'(req_ready), 1, "R4 req_ready pulse");
        @(posedge clk); #1;
        check(32'(req_ready), 0, "R4 req_ready one cycle");
        hread(2'd0, 8'h80, "R4 controller busy set");

        // R4 clear, R3 overrun
        hwrite(2'd0, 8'h01);
        check(32'(req_len), 0, "R4 count cleared");
        for (int i = 0; i < REQ_DEPTH + 2; i++) hwrite(2'd1, 8'h10 + 8'(i));
        check(32'(req_len), REQ_DEPTH + 2, "R3 overrun count");
        #1 req_ridx = REQ_AW'(REQ_DEPTH - 1);
        #1 check(32'(req_rbyte), 32'h10 + REQ_DEPTH - 1, "R3 last slot kept");

        // R11 response post, R5/R6 readout
        bmc_byte(0, 8'h11); bmc_byte(1, 8'h22); bmc_byte(2, 8'h33);
        bmc_post(3);
        hread(2'd0, 8'h08, "R11 busy clear attention set");
        check(32'(irq), 0, "R11 no irq while disabled");
        hread(2'd1, 8'h11, "R5 first byte");
        hwrite(2'd0, 8'h02);
        hread(2'd1, 8'h11, "R6 rewind");
        hread(2'd1, 8'h22, "R5 second byte");
        hread(2'd1, 8'h33, "R5 third byte");
        hread(2'd1, 8'hFF, "R5 drained");
        hwrite(2'd0, 8'h02);
        hread(2'd1, 8'hFF, "R5 length zeroed after last byte");

        // R7 host busy toggle
        hwrite(2'd0, 8'h40);
        hread(2'd0, 8'h48, "R7 toggle on");
        hwrite(2'd0, 8'h40);
        hread(2'd0, 8'h08, "R7 toggle off");

        // R9 / R10 mask behaviour
        hwrite(2'd2, 8'h01);
        check(32'(irq), 1, "R9 enable with attention");
        hread(2'd2, 8'h03, "R9 mask pending");
        hwrite(2'd2, 8'h03);
        check(32'(irq), 0, "R10 pending write-one clear");
        hread(2'd2, 8'h01, "R10 mask after clear");
        hwrite(2'd2, 8'h00);
        hwrite(2'd2, 8'h01);
        check(32'(irq), 1, "R9 re-enable raises");
        hwrite(2'd2, 8'h00);
        check(32'(irq), 0, "R10 disable lowers");
        hread(2'd2, 8'h00, "R10 mask disabled");

        // R8 clear response attention, enable with none
        hwrite(2'd0, 8'h08);
        hread(2'd0, 8'h00, "R8 response attention cleared");
        hwrite(2'd2, 8'h01);
        check(32'(irq), 0, "R9 no attention no irq");

        // R11 post with enable
        bmc_byte(0, 8'h44);
        bmc_post(1);
        check(32'(irq), 1, "R11 post raises irq");
        hread(2'd2, 8'h03, "R11 mask pending");
        hread(2'd1, 8'h44, "R5 single byte");
        hread(2'd1, 8'hFF, "R5 single drained");
        hwrite(2'd2, 8'h03);
        hwrite(2'd0, 8'h08);
        check(32'(irq), 0, "R10 cleared before message test");

        // R12 message attention
        bmc_sms(1'b1);
        check(32'(irq), 1, "R12 set raises irq");
        hread(2'd0, 8'h10, "R12 message attention visible");
        bmc_sms(1'b0);
        check(32'(irq), 0, "R12 clear drops irq");
        hread(2'd0, 8'h00, "R12 message attention cleared");

        bmc_post(0);
        hwrite(2'd2, 8'h03);
        bmc_sms(1'b1);
        check(32'(irq), 0, "R12 no raise with response attention");
        hread(2'd0, 8'h18, "R12 both attentions");
        hwrite(2'd0, 8'h10);
        hread(2'd0, 8'h08, "R8 message attention write-one clear");

        repeat (2) @(posedge clk);
        check(32'(exp_q.size()), 0, "R2 scoreboard drained");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule